// File: doc/BRIEF.md
# Fractional Pixel Clock Waveform Generator

This block derives a pixel clock from a faster system clock. The length of each pixel clock period is set by a fractional divider with four fraction bits, so a period may be, for example, 6.25 system cycles. The block cannot place an edge between system clock edges. It therefore quantises each period boundary to the next system clock edge and carries the unused fraction into the following period. Over many periods the average rate then matches the programmed value exactly.

Within each period, the position of the rising edge and the position of the falling edge are both programmable, in quarter system cycles. This lets a downstream converter receive a high phase that is shorter or longer than half a period, placed where it needs it.

All timing comes from one 32-bit timing word. Software can supply that word directly. Alternatively, a small front end builds it from a divider value plus a start and a width given in sixteenths of the period. The front end also applies range limits and a fallback shape. A new word takes effect only at a period boundary. The outputs are the clock itself and a one-cycle marker at the start of every period.

Top module: `pclk_wavegen`

## Requirements
- R1: Timing word layout: bits [11:0] hold the period in sixteenths of a system cycle (8.4 fixed point), bits [21:12] hold the rise position and bits [31:22] hold the fall position, both in quarter system cycles. A period below 4.0 cycles (raw 64) is treated as 4.0.
- R2: With period P sixteenths, each period lasts either floor(P/16) or ceil(P/16) system cycles. `period_start` is high for exactly the first cycle of each period.
- R3: Over any run of N whole periods, the total cycle count C satisfies |16·C − N·P| < 16.
- R4: `pix_clk` is high in a cycle exactly when the phase within the period is at least 4·rise and below 4·fall. Per period, the number of high cycles is within one cycle of (min(4·fall, P) − 4·rise)/16 (zero if negative). The first high cycle is within one cycle of 4·rise/16 after the period starts.
- R5: A timing word change is taken only at a period boundary. The period in progress completes with the old length.
- R6: Reset is synchronous and active high. During reset, `pix_clk` and `period_start` are low and the phase returns to zero. After release, the first `period_start` appears ceil(P/16) cycles later.
- R7: When `cfg_sel` is 1, the front end raises a divider below 64 to 64 and clamps a divider above 4095 to 4095. The result becomes the period field.
- R8: When `cfg_sel` is 1, the front end sets rise = ((div·start)/16)>>2 and fall = ((div·(start+width))/16)>>2, using integer arithmetic.
- R9: If start and width are both zero, or start+width exceeds 16, the front end uses start 0 and width 7 instead.
- R10: When `cfg_sel` is 0, `tword` is used unchanged and the divider, start and width inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sel | input | 1 | 1: build the word from the divider inputs; 0: use `tword` |
| tword | input | 32 | Directly supplied timing word |
| div_req | input | 16 | Requested divider, 8.4 fixed point |
| hi_start | input | 5 | High phase start in sixteenths of the period |
| hi_width | input | 5 | High phase width in sixteenths of the period |
| pix_clk | output | 1 | Generated pixel clock |
| period_start | output | 1 | One-cycle marker at the start of each period |

## Verification
The bench builds the block with its default parameters: a 16-bit divider input and 5-bit sixteenth inputs. Because the divider input is wider than the 12-bit period field, the bench can request 0xFFFF and exercise the upper clamp. Because the sixteenth inputs reach 31, start+width values above 16 are reachable, which exercises the fallback. Random periods between 4 and 25 cycles, each with a random fraction, show the carried remainder keeping the average exact while individual periods alternate between two lengths.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    localparam int PER_W     = 12;   // period field, 8.4 fixed point
    localparam int EDGE_W    = 10;   // edge fields, quarter cycles
    localparam int SUBSTEP   = 16;   // phase units per system cycle
    localparam int MIN_PER   = 64;   // 4.0 cycles in sixteenths
    localparam int DEF_START = 0;
    localparam int DEF_WIDTH = 7;
    localparam int SIXT_FULL = 16;   // one whole period in sixteenths
    localparam int Q_SHIFT   = 2;    // quarters to sixteenths
    localparam int B_SHIFT   = 4 + Q_SHIFT; // divide by 16 then by 4

    typedef struct packed {
        logic [EDGE_W-1:0] fall;
        logic [EDGE_W-1:0] rise;
        logic [PER_W-1:0]  per;
    } timing_t;

    localparam int WORD_W = $bits(timing_t);

endpackage

// File: rtl/pclk_word_build.sv
module pclk_word_build
    import pclk_pkg::*;
#(
    parameter int DIV_IN_W = 16,
    parameter int FRAC_W   = 5
) (
    input  logic [DIV_IN_W-1:0] div_req,
    input  logic [FRAC_W-1:0]   hi_start,
    input  logic [FRAC_W-1:0]   hi_width,
    output timing_t             word
);
    localparam int PROD_W = PER_W + FRAC_W + 1;
    localparam logic [DIV_IN_W-1:0] DIV_LO = DIV_IN_W'(MIN_PER);
    localparam logic [DIV_IN_W-1:0] DIV_HI = DIV_IN_W'((1 << PER_W) - 1);
    localparam logic [FRAC_W:0]     FULL   = (FRAC_W+1)'(SIXT_FULL);

    logic [PER_W-1:0]  div_c;
    logic [FRAC_W:0]   s_in, e_in, s_eff, e_eff;
    logic              use_def;
    logic [PROD_W-1:0] p_up, p_dn;

    always_comb begin
        if (div_req < DIV_LO)      div_c = PER_W'(MIN_PER);
        else if (div_req > DIV_HI) div_c = '1;
        else                       div_c = div_req[PER_W-1:0];

        s_in    = {1'b0, hi_start};
        e_in    = s_in + {1'b0, hi_width};
        use_def = ((hi_start == '0) && (hi_width == '0)) || (e_in > FULL);
        s_eff   = use_def ? (FRAC_W+1)'(DEF_START) : s_in;
        e_eff   = use_def ? (FRAC_W+1)'(DEF_START + DEF_WIDTH) : e_in;

        p_up = PROD_W'(div_c) * PROD_W'(s_eff);
        p_dn = PROD_W'(div_c) * PROD_W'(e_eff);

        word.per  = div_c;
        word.rise = p_up[B_SHIFT +: EDGE_W];
        word.fall = p_dn[B_SHIFT +: EDGE_W];
    end

endmodule

// File: rtl/pclk_phase_core.sv
module pclk_phase_core
    import pclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  timing_t word_in,
    output logic    pix_clk,
    output logic    period_start
);
    localparam int PH_W = PER_W + 1;
    localparam logic [PH_W-1:0] STEP = PH_W'(SUBSTEP);
    localparam logic [PH_W-1:0] MINP = PH_W'(MIN_PER);

    timing_t         act, nw;
    logic [PH_W-1:0] ph, nxt, ph_n, per_eff;
    logic [PH_W-1:0] up16, dn16;
    logic            wrap, hi_n;

    always_comb begin
        per_eff = ({1'b0, act.per} < MINP) ? MINP : {1'b0, act.per};
        nxt     = ph + STEP;
        wrap    = (nxt >= per_eff);
        ph_n    = wrap ? (nxt - per_eff) : nxt;
        nw      = wrap ? word_in : act;
        up16    = PH_W'({nw.rise, {Q_SHIFT{1'b0}}});
        dn16    = PH_W'({nw.fall, {Q_SHIFT{1'b0}}});
        hi_n    = (ph_n >= up16) && (ph_n < dn16);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph           <= '0;
            act          <= word_in;
            pix_clk      <= 1'b0;
            period_start <= 1'b0;
        end else begin
            ph           <= ph_n;
            act          <= nw;
            pix_clk      <= hi_n;
            period_start <= wrap;
        end
    end

    // R6
    rst_low_chk: assert property (@(posedge clk) rst |=> (!pix_clk && !period_start));

    // R2
    pst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        period_start |=> !period_start);

    // R3
    phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ph < per_eff);

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!period_start && !$past(rst)) |-> $stable(act));

endmodule

// File: rtl/pclk_wavegen.sv
module pclk_wavegen
    import pclk_pkg::*;
#(
    parameter int DIV_IN_W = 16,
    parameter int FRAC_W   = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_sel,
    input  logic [31:0]         tword,
    input  logic [DIV_IN_W-1:0] div_req,
    input  logic [FRAC_W-1:0]   hi_start,
    input  logic [FRAC_W-1:0]   hi_width,
    output logic                pix_clk,
    output logic                period_start
);
    timing_t built, sel_word;

    pclk_word_build #(.DIV_IN_W(DIV_IN_W), .FRAC_W(FRAC_W)) u_build (
        .div_req  (div_req),
        .hi_start (hi_start),
        .hi_width (hi_width),
        .word     (built)
    );

    assign sel_word = cfg_sel ? built : timing_t'(tword[WORD_W-1:0]);

    pclk_phase_core u_core (
        .clk          (clk),
        .rst          (rst),
        .word_in      (sel_word),
        .pix_clk      (pix_clk),
        .period_start (period_start)
    );

    // R7
    build_range_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_sel |-> ((built.per >= PER_W'(MIN_PER)) &&
                     ({2'b0, built.fall, 2'b00} <= (EDGE_W+4)'(built.per))));

endmodule

// File: tb/sim_pclk_wavegen.sv
`timescale 1ns/1ps
module sim_pclk_wavegen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_sel = 1'b0;
    logic [31:0] tword = '0;
    logic [15:0] div_req = '0;
    logic [4:0]  hi_start = '0;
    logic [4:0]  hi_width = '0;
    logic        pix_clk, period_start;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    pclk_wavegen u0 (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .tword(tword),
        .div_req(div_req), .hi_start(hi_start), .hi_width(hi_width),
        .pix_clk(pix_clk), .period_start(period_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Front end per R7, R8, R9
    function automatic logic [31:0] exp_word(input int dv, input int s, input int w);
        int d, r, f;
        d = (dv < 64) ? 64 : ((dv > 4095) ? 4095 : dv);
        if ((s == 0 && w == 0) || (s + w > 16)) begin s = 0; w = 7; end
        r = ((d * s) / 16) >> 2;
        f = ((d * (s + w)) / 16) >> 2;
        return {10'(f), 10'(r), 12'(d)};
    endfunction

    function automatic logic [31:0] mk_raw(input int per, input int rise, input int fall);
        return {10'(fall), 10'(rise), 12'(per)};
    endfunction

    task automatic wait_pst();
        do @(negedge clk); while (!period_start);
    endtask

    // Measure n periods; call at a negedge where period_start is high.
    task automatic measure(input logic [31:0] wd, input int n, input string tg);
        int p, up, dn, wv, fl, ce, tot;
        p   = (int'(wd[11:0]) < 64) ? 64 : int'(wd[11:0]);
        up  = int'(wd[21:12]) * 4;
        dn  = int'(wd[31:22]) * 4;
        wv  = ((dn < p) ? dn : p) - up;
        if (wv < 0) wv = 0;
        fl  = p / 16;
        ce  = (p + 15) / 16;
        tot = 0;
        for (int k = 0; k < n; k++) begin
            int len, hi, first;
            len = 0; hi = 0; first = -1;
            do begin
                if (pix_clk) begin
                    hi++;
                    if (first < 0) first = len;
                end
                len++;
                @(negedge clk);
            end while (!period_start);
            tot += len;
            chk(len == fl || len == ce, {"R2 period length ", tg}, len, ce);
            chk(iabs(16 * hi - wv) < 16, {"R4 high cycles ", tg}, 16 * hi, wv);
            if (hi > 0)
                chk(iabs(16 * first - up) < 16, {"R4 rise offset ", tg}, 16 * first, up);
        end
        chk(iabs(16 * tot - n * p) < 16, {"R3 average period ", tg}, 16 * tot, n * p);
    endtask

    task automatic run_raw(input logic [31:0] wd, input int n, input string tg);
        cfg_sel = 1'b0;
        tword   = wd;
        div_req = 16'($urandom_range(0, 65535));
        hi_start = 5'($urandom_range(0, 31));
        hi_width = 5'($urandom_range(0, 31));
        wait_pst();
        measure(wd, n, tg);
    endtask

    task automatic run_build(input int dv, input int s, input int w, input int n, input string tg);
        cfg_sel  = 1'b1;
        tword    = 32'($urandom());
        div_req  = 16'(dv);
        hi_start = 5'(s);
        hi_width = 5'(w);
        wait_pst();
        measure(exp_word(dv, s, w), n, tg);
    endtask

    function automatic void summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R6: reset state and restart
        tword = mk_raw(100, 4, 20);
        repeat (3) @(negedge clk);
        chk(!pix_clk, "R6 pix low in reset", int'(pix_clk), 0);
        chk(!period_start, "R6 marker low in reset", int'(period_start), 0);
        rst = 1'b0;
        begin
            int k = 0;
            do begin @(negedge clk); k++; end while (!period_start && k < 100);
            chk(k == 7, "R6 first marker after release", k, 7);
        end
        measure(mk_raw(100, 4, 20), 8, "R1 R10 raw 6.25");

        // R1: sub-minimum raw period treated as 4.0
        run_raw(mk_raw(20, 0, 8), 6, "R1 min period");
        // R4: rise not below fall never high; fall past end of period
        run_raw(mk_raw(150, 20, 10), 4, "R4 empty high");
        run_raw(mk_raw(150, 10, 200), 4, "R4 fall clipped");
        // R7: clamps
        run_build(16'h0010, 4, 8, 6, "R7 low clamp");
        run_build(16'hFFFF, 2, 5, 3, "R7 high clamp");
        // R9: fallback shapes
        run_build(16'h0080, 0, 0, 6, "R9 zero fallback");
        run_build(16'h0093, 10, 9, 6, "R9 overflow fallback");
        // R8: full-period high and late edge
        run_build(16'h00A7, 0, 16, 6, "R8 full width");
        run_build(16'h0135, 12, 4, 6, "R8 late high");

        // R5: change word mid-period, in-flight period keeps old length
        cfg_sel = 1'b0;
        tword = mk_raw(128, 0, 16);
        wait_pst();
        wait_pst();
        begin
            int k = 2;
            @(negedge clk); @(negedge clk);
            tword = mk_raw(80, 0, 8);
            while (!period_start) begin @(negedge clk); k++; end
            chk(k == 8, "R5 old period completes", k, 8);
            k = 0;
            do begin @(negedge clk); k++; end while (!period_start);
            chk(k == 5, "R5 new period applied", k, 5);
        end

        // Random mix
        for (int i = 0; i < 24; i++) begin
            if (i % 2 == 0) begin
                int per = $urandom_range(64, 400);
                run_raw(mk_raw(per, $urandom_range(0, per / 4), $urandom_range(0, per / 4)),
                        6, "R1 R10 random raw");
            end else begin
                run_build($urandom_range(40, 420), $urandom_range(0, 16),
                          $urandom_range(0, 16), 6, "R8 random build");
            end
        end

        summary();
        $finish;
    end

endmodule